// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a 64-entry, 8-bit register file. The serial side uses clock polarity 1 and clock phase 1. The serial clock idles high. The slave samples incoming bits on the rising edge and changes outgoing bits on the falling edge. Each transaction opens with a command byte that holds a read flag, a burst flag and a 6-bit register address. One or more data bytes follow. In burst mode the register pointer advances after every byte.

The data pins work in one of two arrangements. In 4-wire operation there are separate input and output lines. In 3-wire operation a single shared line carries data in both directions, and that line appears here as pad-level input, output and enable signals. Bit 6 of register 0x31, written over the bus, selects the arrangement. All serial inputs are resampled into a system clock that runs at least four times faster than the serial clock. On the parallel side the block presents every register's contents and a one-cycle write strobe per register.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0, the port is in 4-wire operation, both output enables are low and no write strobe is active.
- R2: The command byte is received MSB first, sampled on rising serial-clock edges: bit 7 = 1 requests a read, bit 6 = 1 requests a burst, bits 5..0 are the start address.
- R3: Without the burst flag, exactly one data byte is written; further bytes in the same transaction change no register.
- R4: Read data leaves MSB first, each bit updated after a falling serial-clock edge and valid at the following rising edge.
- R5: In a burst write each completed data byte goes to the current address, then the address advances by one, wrapping from 63 to 0.
- R6: In a burst read successive bytes come from successive addresses, wrapping from 63 to 0.
- R7: Bit 6 of register 0x31 selects 3-wire operation when 1 and 4-wire operation when 0; a change takes effect only from the next transaction.
- R8: In 4-wire operation the output enable is high only while chip select is low. In 3-wire operation the shared-pin enable is high only during the data phase of a read. The two enables are never high together.
- R9: A byte left incomplete when chip select rises is discarded and writes nothing.
- R10: Each written byte produces a single-cycle strobe on the one reg_wstb bit that matches its address, and reg_flat bits [8a+7:8a] show register a.
- R11: Serial-clock and data activity while chip select is high changes no register and no transaction state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, idles high |
| spi_mosi | input | 1 | Serial data in (4-wire operation) |
| spi_so | output | 1 | Serial data out (4-wire operation) |
| spi_so_oe | output | 1 | Output enable for spi_so |
| spi_sdio_i | input | 1 | Shared data pin, pad input (3-wire operation) |
| spi_sdio_o | output | 1 | Shared data pin, pad output |
| spi_sdio_oe | output | 1 | Shared data pin, pad output enable |
| reg_flat | output | 512 | All registers, register a at bits [8a+7:8a] |
| reg_wstb | output | 64 | One-cycle write strobe per register |

## Verification
The bench runs burst writes and reads across the 63-to-0 boundary. A pointer that saturates or resets instead of wrapping would put bytes in the wrong registers. It ends a transaction in the middle of a byte; a design that flushes a partial shift register on deselect would leave a spurious write. It changes the wire mode inside a burst and keeps driving that burst in the old mode. A design that switches immediately would read the next byte from the wrong pin and store 0xFF. The 3-wire checks look at the shared-pin enable during the command phase. They also put inverted data on the unused input, so a design that reads the wrong pin or drives the pin early is caught.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Transaction phase of the serial engine
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // chip select high
    PH_CMD  = 2'd1,  // receiving the command byte
    PH_DATA = 2'd2,  // moving data bytes
    PH_HOLD = 2'd3   // single access done, wait for deselect
  } spi_phase_e;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("spi_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int CFG_ADDR = 49,
  parameter int CFG_BIT  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0] flat,
  output logic [(1<<ADDR_W)-1:0]   wstb,
  output logic                     cfg_3w
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]        wen;
  logic [DEPTH-1:0]        wstb_q;

  // per-entry write enable decode
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
      assign wen[i] = we & (addr == ADDR_W'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wen[i]) mem_q[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wstb_q <= '0;
    else        wstb_q <= wen;
  end

  assign rdata  = mem_q[int'(addr)*DATA_W +: DATA_W];
  assign flat   = mem_q;
  assign wstb   = wstb_q;
  assign cfg_3w = mem_q[CFG_ADDR*DATA_W + CFG_BIT];

  // R10
  wstb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb_q));

  // R11
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_q));

endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic              sdio_s,
  input  logic              cfg_3w,
  input  logic [DATA_W-1:0] rdata,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              so,
  output logic              so_oe,
  output logic              sdio_o,
  output logic              sdio_oe
);

  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  // registers
  logic              sck_prev_q, sck_prev_d;
  spi_phase_e        phase_q, phase_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic [DATA_W-2:0] rx_q, rx_d;
  logic [DATA_W-2:0] tx_q, tx_d;
  logic              rd_q, rd_d;
  logic              mb_q, mb_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              out_q, out_d;
  logic              m3w_q, m3w_d;

  // combinational helpers
  logic              sck_rise, sck_fall, din, byte_end;
  logic [DATA_W-1:0] byte_w;
  spi_phase_e        ph;

  assign sck_rise = sck_s & ~sck_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;
  assign din      = m3w_q ? sdio_s : mosi_s;
  assign byte_w   = {rx_q, din};
  assign byte_end = sck_rise & (bcnt_q == LAST_BIT);
  assign ph       = (phase_q == PH_IDLE) ? PH_CMD : phase_q;

  // next-state logic
  always_comb begin
    sck_prev_d = sck_s;
    phase_d    = phase_q;
    bcnt_d     = bcnt_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    rd_d       = rd_q;
    mb_d       = mb_q;
    addr_d     = addr_q;
    out_d      = out_q;
    m3w_d      = m3w_q;
    we         = 1'b0;

    if (csn_s) begin
      phase_d = PH_IDLE;
      bcnt_d  = '0;
      m3w_d   = cfg_3w;
    end else begin
      phase_d = ph;
      if (sck_rise) begin
        rx_d   = byte_w[DATA_W-2:0];
        bcnt_d = byte_end ? '0 : bcnt_q + BC_W'(1);
        if (byte_end) begin
          case (ph)
            PH_CMD: begin
              rd_d    = byte_w[DATA_W-1];
              mb_d    = byte_w[DATA_W-2];
              addr_d  = byte_w[ADDR_W-1:0];
              phase_d = PH_DATA;
            end
            PH_DATA: begin
              we = ~rd_q;
              if (mb_q) addr_d  = addr_q + ADDR_W'(1);
              else      phase_d = PH_HOLD;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && rd_q) begin
        if (ph == PH_DATA) begin
          if (bcnt_q == '0) begin
            out_d = rdata[DATA_W-1];
            tx_d  = rdata[DATA_W-2:0];
          end else begin
            out_d = tx_q[DATA_W-2];
            tx_d  = {tx_q[DATA_W-3:0], 1'b0};
          end
        end else if (ph == PH_HOLD) begin
          out_d = 1'b0;
        end
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b1;
      phase_q    <= PH_IDLE;
      bcnt_q     <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rd_q       <= 1'b0;
      mb_q       <= 1'b0;
      addr_q     <= '0;
      out_q      <= 1'b0;
      m3w_q      <= 1'b0;
    end else begin
      sck_prev_q <= sck_prev_d;
      phase_q    <= phase_d;
      bcnt_q     <= bcnt_d;
      rx_q       <= rx_d;
      tx_q       <= tx_d;
      rd_q       <= rd_d;
      mb_q       <= mb_d;
      addr_q     <= addr_d;
      out_q      <= out_d;
      m3w_q      <= m3w_d;
    end
  end

  assign addr    = addr_q;
  assign wdata   = byte_w;
  assign so      = out_q;
  assign sdio_o  = out_q;
  assign so_oe   = ~csn_s & ~m3w_q;
  assign sdio_oe = ~csn_s & m3w_q & rd_q & (phase_q == PH_DATA);

  // R9
  idle_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (phase_q == PH_IDLE && bcnt_q == '0));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !csn_s) |=> $stable(m3w_q));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !csn_s && phase_q == PH_DATA && mb_q)
      |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R3
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !csn_s && phase_q == PH_DATA && !mb_q) |=> (phase_q == PH_HOLD));

  // R8
  pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !so_oe);

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int DATA_W      = 8,
  parameter int CFG_ADDR    = 49,
  parameter int CFG_BIT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_so,
  output logic spi_so_oe,
  input  logic spi_sdio_i,
  output logic spi_sdio_o,
  output logic spi_sdio_oe,
  output logic [(1<<(DATA_W-2))*DATA_W-1:0] reg_flat,
  output logic [(1<<(DATA_W-2))-1:0]        reg_wstb
);

  localparam int ADDR_W = DATA_W - 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // pin resampling: {sdio, mosi, csn, sck}
  logic [3:0] pins_s;
  logic       sck_s, csn_s, mosi_s, sdio_s;

  spi_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1111)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d    ({spi_sdio_i, spi_mosi, spi_csn, spi_sck}),
    .q    (pins_s)
  );

  assign sck_s  = pins_s[0];
  assign csn_s  = pins_s[1];
  assign mosi_s = pins_s[2];
  assign sdio_s = pins_s[3];

  logic              we, cfg_3w;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  spi_engine #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .sck_s  (sck_s),
    .csn_s  (csn_s),
    .mosi_s (mosi_s),
    .sdio_s (sdio_s),
    .cfg_3w (cfg_3w),
    .rdata  (rdata),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .so     (spi_so),
    .so_oe  (spi_so_oe),
    .sdio_o (spi_sdio_o),
    .sdio_oe(spi_sdio_oe)
  );

  spi_regfile #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CFG_ADDR(CFG_ADDR),
    .CFG_BIT (CFG_BIT)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .flat  (reg_flat),
    .wstb  (reg_wstb),
    .cfg_3w(cfg_3w)
  );

  // R10
  strobe_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|reg_wstb) |-> !$past(csn_s));

endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;

  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1;
  logic spi_sck = 1'b1;
  logic spi_mosi = 1'b1;
  logic m_sdio = 1'b1;
  logic spi_so, spi_so_oe, spi_sdio_o, spi_sdio_oe, spi_sdio_i;
  logic [511:0] reg_flat;
  logic [63:0]  reg_wstb;

  always #4 clk = ~clk;  // 125 MHz

  // pad model for the shared pin
  assign spi_sdio_i = spi_sdio_oe ? spi_sdio_o : m_sdio;

  spi_regport u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .spi_so     (spi_so),
    .spi_so_oe  (spi_so_oe),
    .spi_sdio_i (spi_sdio_i),
    .spi_sdio_o (spi_sdio_o),
    .spi_sdio_oe(spi_sdio_oe),
    .reg_flat   (reg_flat),
    .reg_wstb   (reg_wstb)
  );

  int errors = 0;
  int checks = 0;
  int wstb_cnt = 0;
  int wstb_multi = 0;
  int wstb_last = -1;
  bit finished = 1'b0;
  bit three_w = 1'b0;

  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  logic       oe_log [64];

  // strobe monitor
  always @(negedge clk) begin
    if (|reg_wstb) begin
      wstb_cnt++;
      if ($countones(reg_wstb) != 1) wstb_multi++;
      for (int i = 0; i < 64; i++) if (reg_wstb[i]) wstb_last = i;
    end
  end

  function automatic logic [7:0] reg_at(input int a);
    return reg_flat[a*8 +: 8];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one transaction of nbits serial clocks
  task automatic xfer(input int nbits);
    logic is_rd;
    logic b;
    is_rd = tx_buf[0][7];
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      b = tx_buf[i/8][7-(i%8)];
      spi_sck = 1'b0;
      if (three_w) begin
        spi_mosi = ~b;
        m_sdio   = (is_rd && i >= 8) ? 1'b1 : b;
      end else begin
        spi_mosi = b;
        m_sdio   = 1'b1;
      end
      repeat (HALF) @(negedge clk);
      rx_buf[i/8][7-(i%8)] = three_w ? spi_sdio_o : spi_so;
      oe_log[i] = three_w ? spi_sdio_oe : spi_so_oe;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_csn  = 1'b1;
    spi_mosi = 1'b1;
    m_sdio   = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic t_reset;
    int nz = 0;
    for (int a = 0; a < 64; a++) if (reg_at(a) != 8'h00) nz++;
    chk("R1 nonzero registers", nz, 0);
    chk("R1 so_oe", int'(spi_so_oe), 0);
    chk("R1 sdio_oe", int'(spi_sdio_oe), 0);
    chk("R1 strobes", wstb_cnt, 0);
  endtask

  task automatic t_single_write;
    int c0 = wstb_cnt;
    tx_buf[0] = 8'h05; tx_buf[1] = 8'hA5; tx_buf[2] = 8'h3C;
    xfer(24);
    chk("R2 write addr 5", int'(reg_at(5)), 8'hA5);
    chk("R3 extra byte ignored reg6", int'(reg_at(6)), 8'h00);
    chk("R10 one strobe", wstb_cnt - c0, 1);
    chk("R10 strobe index", wstb_last, 5);
  endtask

  task automatic t_single_read;
    int oe_bad = 0;
    tx_buf[0] = 8'h85; tx_buf[1] = 8'h00;
    xfer(16);
    chk("R4 read addr 5", int'(rx_buf[1]), 8'hA5);
    for (int i = 0; i < 16; i++) if (oe_log[i] !== 1'b1) oe_bad++;
    chk("R8 so_oe low while selected", oe_bad, 0);
    chk("R8 so_oe after deselect", int'(spi_so_oe), 0);
  endtask

  task automatic t_burst_write;
    int c0 = wstb_cnt;
    tx_buf[0] = 8'h7E; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22;
    tx_buf[3] = 8'h33; tx_buf[4] = 8'h44;
    xfer(40);
    chk("R5 reg 0x3E", int'(reg_at(62)), 8'h11);
    chk("R5 reg 0x3F", int'(reg_at(63)), 8'h22);
    chk("R5 wrap reg 0x00", int'(reg_at(0)), 8'h33);
    chk("R5 reg 0x01", int'(reg_at(1)), 8'h44);
    chk("R10 four strobes", wstb_cnt - c0, 4);
    chk("R10 last strobe index", wstb_last, 1);
  endtask

  task automatic t_burst_read;
    tx_buf[0] = 8'hFF;
    for (int k = 1; k < 4; k++) tx_buf[k] = 8'h00;
    xfer(32);
    chk("R6 byte from 0x3F", int'(rx_buf[1]), 8'h22);
    chk("R6 wrap byte from 0x00", int'(rx_buf[2]), 8'h33);
    chk("R6 byte from 0x01", int'(rx_buf[3]), 8'h44);
  endtask

  task automatic t_partial;
    int c0 = wstb_cnt;
    tx_buf[0] = 8'h10; tx_buf[1] = 8'hFF;
    xfer(13);
    chk("R9 partial byte reg 0x10", int'(reg_at(16)), 8'h00);
    chk("R9 no strobe", wstb_cnt - c0, 0);
  endtask

  task automatic t_deselected_traffic;
    int c0 = wstb_cnt;
    logic [511:0] snap = reg_flat;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      spi_sck  = 1'b0;
      spi_mosi = i[0];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_mosi = 1'b1;
    repeat (4*HALF) @(negedge clk);
    chk("R11 no strobe", wstb_cnt - c0, 0);
    chk("R11 registers unchanged", int'(reg_flat == snap), 1);
    tx_buf[0] = 8'h85; tx_buf[1] = 8'h00;
    xfer(16);
    chk("R11 framing intact after idle clocks", int'(rx_buf[1]), 8'hA5);
  endtask

  task automatic t_three_wire;
    int oe_cmd = 0;
    int oe_dat = 0;
    // switch inside a 4-wire burst; second byte must still use the 4-wire input
    three_w = 1'b0;
    tx_buf[0] = 8'h71; tx_buf[1] = 8'h40; tx_buf[2] = 8'h77;
    xfer(24);
    chk("R7 config reg 0x31", int'(reg_at(49)), 8'h40);
    chk("R7 deferred switch reg 0x32", int'(reg_at(50)), 8'h77);
    // 3-wire read
    three_w = 1'b1;
    tx_buf[0] = 8'h85; tx_buf[1] = 8'h00;
    xfer(16);
    chk("R7 3-wire read", int'(rx_buf[1]), 8'hA5);
    for (int i = 0; i < 8; i++) if (oe_log[i] !== 1'b0) oe_cmd++;
    for (int i = 8; i < 16; i++) if (oe_log[i] !== 1'b1) oe_dat++;
    chk("R8 sdio_oe in command phase", oe_cmd, 0);
    chk("R8 sdio_oe in read data phase", oe_dat, 0);
    chk("R8 so_oe in 3-wire", int'(spi_so_oe), 0);
    chk("R8 sdio_oe after deselect", int'(spi_sdio_oe), 0);
    // 3-wire write, 4-wire input carries inverted bits
    tx_buf[0] = 8'h20; tx_buf[1] = 8'h5A;
    xfer(16);
    chk("R7 3-wire write reg 0x20", int'(reg_at(32)), 8'h5A);
    // back to 4-wire
    tx_buf[0] = 8'h31; tx_buf[1] = 8'h00;
    xfer(16);
    three_w = 1'b0;
    tx_buf[0] = 8'hA0; tx_buf[1] = 8'h00;
    xfer(16);
    chk("R7 back in 4-wire read 0x20", int'(rx_buf[1]), 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_single_write();
    t_single_read();
    t_burst_write();
    t_burst_read();
    t_partial();
    t_deselected_traffic();
    t_three_wire();
    chk("R10 strobes one-hot", wstb_multi, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule